// File: doc/BRIEF.md
# DMA Channel Resume Controller

This block keeps the run state and the beat progress of a single DMA channel. Software programs the channel through a small register write port. A write to the control register switches the channel on or off. A write to the count register or to either address register changes the channel's setup. The datapath sends a one-cycle pulse for every beat it completes, and the block counts the remaining beats down until none are left.

When software switches the channel back on, the block chooses one of three outcomes. If any setup register was written while the channel was off, it starts a new transfer from the programmed count and raises a one-cycle pulse that tells the datapath to take the new setup. If no setup register was written, it resumes with the beats that were still outstanding. If no beats were outstanding, it stays idle. Setup writes that arrive while the channel runs are dropped.

Register map (2-bit address): 0 = control (data bit 0 is the enable), 1 = beat count (all data bits), 2 = source address, 3 = destination address. The block only records whether an address register was written. It does not store the address value.

Top module: `dma_resume_ctl`

## Requirements
- R1: After reset, `active` is 0, `remaining` is 0 and `load_fresh` is 0.
- R2: While `active` is 1, each `beat_done` pulse lowers `remaining` by exactly one. While `active` is 0, `beat_done` is ignored.
- R3: The beat that brings `remaining` to 0 also clears `active`. `active` is never 1 while `remaining` is 0.
- R4: Writing 0 to the enable bit (address 0, data bit 0) while the channel runs clears `active` after the write edge and keeps `remaining` at its value.
- R5: Switching the channel on with no setup write since the last load resumes with the current `remaining`. `load_fresh` stays 0.
- R6: A write to address 1, 2 or 3 while the channel is off makes the next switch-on load the programmed count into `remaining`. On that switch-on, `load_fresh` is 1 for exactly one cycle.
- R7: Switching the channel on after it has completed, with no setup write in between, leaves `active` at 0 and `remaining` at 0.
- R8: Writes to addresses 1, 2 and 3 while the channel runs change nothing. A later off/on sequence resumes without a load.
- R9: Writing 1 to the enable bit while the channel already runs does not change `remaining` and does not pulse `load_fresh`.
- R10: A switch-on that loads a programmed count of 0 still pulses `load_fresh`, but the channel stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| beat_done | input | 1 | One pulse per completed beat |
| active | output | 1 | Channel is issuing transfers |
| remaining | output | CNT_W | Beats still to be moved |
| load_fresh | output | 1 | One-cycle pulse to take the new setup |

## Verification
The assertions check these rules on every cycle:
- a running channel never holds a zero count;
- each accepted beat lowers the count by exactly one;
- an idle channel's count moves only on a switch-on;
- the load pulse lasts one cycle and never follows a running cycle.

The choice between resume, restart and no action depends on setup writes made earlier. Only the bench's scenarios can show that choice. The bench sweeps beat counts and stop points, then compares every count and pulse against values it computes itself.

// File: rtl/dma_resume_ctl.sv
module dma_resume_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             beat_done,
  output logic             active,
  output logic [CNT_W-1:0] remaining,
  output logic             load_fresh
);

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;

  logic             en_q;
  logic             dirty;
  logic [CNT_W-1:0] prog_cnt;
  logic [CNT_W-1:0] left_q;
  logic             load_q;

  wire              wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  wire              wr_cfg    = wr_en && (wr_addr != A_CTRL);
  wire              turn_on   = wr_ctrl && wr_data[0] && !en_q;
  wire              turn_off  = wr_ctrl && !wr_data[0];
  wire [CNT_W-1:0]  start_cnt = dirty ? prog_cnt : left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      dirty    <= 1'b0;
      prog_cnt <= '0;
      left_q   <= '0;
      load_q   <= 1'b0;
    end else begin
      load_q <= turn_on && dirty;
      if (en_q) begin
        if (beat_done) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) en_q <= 1'b0;
        end
        if (turn_off) en_q <= 1'b0;
      end else begin
        if (wr_cfg) dirty <= 1'b1;
        if (wr_en && wr_addr == A_COUNT) prog_cnt <= wr_data;
        if (turn_on) begin
          left_q <= start_cnt;
          en_q   <= (start_cnt != '0);
          dirty  <= 1'b0;
        end
      end
    end
  end

  assign active     = en_q;
  assign remaining  = left_q;
  assign load_fresh = load_q;

  AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (remaining != '0)); // R3

  AST_BEAT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (active && beat_done) |=> (remaining == $past(remaining) - 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(wr_ctrl && wr_data[0])) |=> $stable(remaining)); // R4

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_fresh |=> !load_fresh); // R6

  AST_NO_LOAD_WHILE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> !load_fresh); // R9

endmodule

// File: tb/test_dma_resume_ctl.sv
module test_dma_resume_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             beat_done = 1'b0;
  logic             active;
  logic [CNT_W-1:0] remaining;
  logic             load_fresh;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_resume_ctl #(.CNT_W(CNT_W)) i_dma_resume_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .beat_done(beat_done), .active(active),
    .remaining(remaining), .load_fresh(load_fresh));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic beat();
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 active", active, 0);
    check("R1 remaining", remaining, 0);
    check("R1 load_fresh", load_fresh, 0);
    wr(0, 1);
    check("R7 reset enable active", active, 0);
    check("R7 reset enable remaining", remaining, 0);

    for (int c = 1; c <= 7; c++) begin
      for (int k = 0; k < c; k++) begin
        wr(1, c);
        wr(0, 1);
        check("R6 load pulse", load_fresh, 1);
        check("R6 loaded count", remaining, c);
        check("R6 active", active, 1);
        @(negedge clk);
        check("R6 pulse one cycle", load_fresh, 0);
        for (int b = 1; b <= k; b++) begin
          beat();
          check("R2 decrement", remaining, c - b);
        end
        wr(0, 0);
        check("R4 stopped", active, 0);
        check("R4 count held", remaining, c - k);
        beat();
        check("R2 idle beat ignored", remaining, c - k);
        wr(0, 1);
        check("R5 resume no load", load_fresh, 0);
        check("R5 resume count", remaining, c - k);
        check("R5 resume active", active, 1);
        for (int b = k + 1; b <= c; b++) begin
          beat();
          check("R2 resumed decrement", remaining, c - b);
        end
        check("R3 finished inactive", active, 0);
        wr(0, 1);
        check("R7 no transfer", active, 0);
        check("R7 no load", load_fresh, 0);
        check("R7 count zero", remaining, 0);
      end
    end

    wr(1, 9);
    wr(0, 1);
    beat(); beat();
    wr(0, 0);
    wr(2, 1234);
    wr(0, 1);
    check("R6 address write restarts", remaining, 9);
    check("R6 address write load", load_fresh, 1);

    wr(1, 200);
    wr(3, 77);
    check("R8 count write ignored", remaining, 9);
    wr(0, 1);
    check("R9 re-enable keeps count", remaining, 9);
    check("R9 re-enable no load", load_fresh, 0);
    beat();
    wr(0, 0);
    wr(0, 1);
    check("R8 resume after ignored writes", remaining, 8);
    check("R8 no load", load_fresh, 0);
    for (int b = 0; b < 8; b++) beat();
    check("R3 done", active, 0);

    wr(1, 0);
    wr(0, 1);
    check("R10 zero load pulse", load_fresh, 1);
    check("R10 stays inactive", active, 0);
    check("R10 count", remaining, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule